// File: doc/BRIEF.md
# CAN Message FIFO Pair with Pointer-Control Registers

This block sits between a CAN protocol engine and the register bus of a host processor. It holds a transmit queue and a receive queue, four frames each by default. Every frame carries a 32-bit identifier word, a 4-bit data length code and eight data bytes. The host never addresses queue entries directly. On the transmit side it fills a staging window and then writes any value to a commit register. On the receive side it reads the oldest frame through a fixed window and then writes any value to a release register.

The protocol engine sees a plain frame handshake. The oldest committed frame is presented with a valid flag, and a one-cycle completion pulse retires it. Received frames arrive with a one-cycle valid pulse. If an arrival finds the receive queue full, the frame is dropped and an overrun pulse goes to the error logic. Two sticky interrupt flags record receive arrivals and transmit completions. Software clears them by writing ones.

The register map uses word addresses. The transmit window is at 0 to 3 and the receive window at 4 to 7; in each window these are the identifier, the length code, data bytes 0-3 and data bytes 4-7. Transmit control is at 8, receive control at 9, transmit commit at 10, receive release at 11 and the interrupt flags at 12. Read data is registered and appears one cycle after the address is presented.

Top module: `can_msg_fifo`

## Requirements
- R1: After reset, both queues are disabled and empty. Transmit control (address 8) reads 0, receive control (address 9) reads 0x80, the flag register (address 12) reads 0, and no frame is offered to the bus.
- R2: A write of any value to address 10 while transmit is enabled copies the staging window into the transmit queue. The queue offers frames oldest first on the frame outputs. The identifier word passes through unchanged, including bit 31 (extended identifier) and bit 30 (remote frame).
- R3: At address 8, bit 0 is the enable (read/write) and bits 3:1 give the number of committed frames not yet completed.
- R4: A commit while four frames are unsent and no completion occurs in the same cycle is ignored. The count stays at 4 and the queued frames are unchanged.
- R5: A completion pulse while a frame is offered removes that frame and sets the transmit flag (bit 1 of address 12). A completion pulse with nothing offered has no effect.
- R6: A frame arriving while receive is enabled and room is available is stored. The receive window shows the oldest stored frame, and bit 7 of address 9 reads 1 exactly when the receive queue is empty (bit 0 is the enable).
- R7: A write of any value to address 11 releases the oldest received frame. On an empty queue it is ignored.
- R8: A frame arriving while four frames are held and no release occurs in the same cycle is discarded. The held frames stay unchanged, and the overrun output pulses high for one cycle on the next cycle.
- R9: The receive flag (bit 0 of address 12) sets when a frame is stored. Writing 1 to a flag bit clears it, and a set in the same cycle wins over the clear. Both flags are also driven to output pins.
- R10: Writing 0 to an enable bit empties that queue. While transmit is disabled, commits are ignored and nothing is offered. While receive is disabled, arrivals are dropped without an overrun pulse and without setting the flag.
- R11: On a full queue, a commit together with a completion, or an arrival together with a release, both take effect. The count stays at 4 and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address (read and write) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| tx_valid_o | output | 1 | Oldest unsent frame is offered |
| tx_id_o | output | 32 | Offered identifier word |
| tx_dlc_o | output | 4 | Offered length code |
| tx_data_o | output | 64 | Offered data, byte 0 in bits 7:0 |
| tx_done_i | input | 1 | Offered frame has been sent |
| rx_valid_i | input | 1 | Received frame pulse |
| rx_id_i | input | 32 | Received identifier word |
| rx_dlc_i | input | 4 | Received length code |
| rx_data_i | input | 64 | Received data, byte 0 in bits 7:0 |
| rx_ovr_o | output | 1 | Overrun pulse for the error logic |
| irq_rx_o | output | 1 | Sticky receive flag |
| irq_tx_o | output | 1 | Sticky transmit-completion flag |

## Verification
The tightest corners come from a full queue being pushed and popped in the same cycle. A receive arrival can coincide with a host release, and a host commit can coincide with a protocol completion. A second collision is a flag clear that lands in the same cycle as a flag set. The bench reaches these cases in directed steps and again through random cycles that draw completion, arrival and register writes independently. Each cycle is judged against a reference pair of queues. That reference decides whether each push and pop takes effect from the occupancy before the edge, and it applies the pop before the push.

// File: rtl/can_mfifo_pkg.sv
package can_mfifo_pkg;
  localparam int ID_W   = 32;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } mfifo_frame_t;

  // word addresses of the register map
  localparam int A_TXW_ID  = 0;
  localparam int A_TXW_DLC = 1;
  localparam int A_TXW_DLO = 2;
  localparam int A_TXW_DHI = 3;
  localparam int A_RXW_ID  = 4;
  localparam int A_RXW_DLC = 5;
  localparam int A_RXW_DLO = 6;
  localparam int A_RXW_DHI = 7;
  localparam int A_TXCTL   = 8;
  localparam int A_RXCTL   = 9;
  localparam int A_TXPTR   = 10;
  localparam int A_RXPTR   = 11;
  localparam int A_FLAGS   = 12;

  localparam int EN_BIT    = 0;
  localparam int EMPTY_BIT = 7;
  localparam int FLAG_RX   = 0;
  localparam int FLAG_TX   = 1;
  localparam int NFLAG     = 2;
endpackage

// File: rtl/mfifo_ring.sv
module mfifo_ring #(
  parameter int W     = 100,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_full_push_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (full && $stable(wp) && $stable(rp)));

  assert_empty_pop_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> (empty && $stable(rp)));
endmodule

// File: rtl/mfifo_flags.sv
module mfifo_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr) | set;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/can_msg_fifo.sv
module can_msg_fifo
  import can_mfifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid_o,
  output logic [ID_W-1:0]   tx_id_o,
  output logic [DLC_W-1:0]  tx_dlc_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_done_i,
  input  logic              rx_valid_i,
  input  logic [ID_W-1:0]   rx_id_i,
  input  logic [DLC_W-1:0]  rx_dlc_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ovr_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int FW = $bits(mfifo_frame_t);

  logic sel_txctl, sel_rxctl, sel_txptr, sel_rxptr, sel_flags;
  assign sel_txctl = bus_wr && (bus_addr == AW'(A_TXCTL));
  assign sel_rxctl = bus_wr && (bus_addr == AW'(A_RXCTL));
  assign sel_txptr = bus_wr && (bus_addr == AW'(A_TXPTR));
  assign sel_rxptr = bus_wr && (bus_addr == AW'(A_RXPTR));
  assign sel_flags = bus_wr && (bus_addr == AW'(A_FLAGS));

  logic         tx_en, rx_en;
  mfifo_frame_t tx_win, tx_head, rx_head, rx_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      tx_win <= '0;
    end else begin
      if (sel_txctl) tx_en <= bus_wdata[EN_BIT];
      if (sel_rxctl) rx_en <= bus_wdata[EN_BIT];
      if (bus_wr) begin
        case (bus_addr)
          AW'(A_TXW_ID):  tx_win.id          <= bus_wdata;
          AW'(A_TXW_DLC): tx_win.dlc         <= bus_wdata[DLC_W-1:0];
          AW'(A_TXW_DLO): tx_win.data[31:0]  <= bus_wdata;
          AW'(A_TXW_DHI): tx_win.data[63:32] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // transmit queue
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_empty, tx_evt, tx_flush;
  assign tx_flush   = sel_txctl && !bus_wdata[EN_BIT];
  assign tx_valid_o = tx_en && !tx_empty;
  assign tx_evt     = tx_done_i && tx_valid_o;

  mfifo_ring #(.W(FW), .DEPTH(DEPTH)) u_tx_ring (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(sel_txptr && tx_en), .pop(tx_evt),
    .din(tx_win), .dout(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  assign tx_id_o   = tx_head.id;
  assign tx_dlc_o  = tx_head.dlc;
  assign tx_data_o = tx_head.data;

  // receive queue
  logic [CW-1:0] rx_cnt;
  logic          rx_full, rx_empty, rx_flush, rx_drop, rx_store;
  assign rx_flush = sel_rxctl && !bus_wdata[EN_BIT];
  assign rx_in    = '{id: rx_id_i, dlc: rx_dlc_i, data: rx_data_i};
  assign rx_drop  = rx_valid_i && rx_en && rx_full && !sel_rxptr;
  assign rx_store = rx_valid_i && rx_en && !rx_drop;

  mfifo_ring #(.W(FW), .DEPTH(DEPTH)) u_rx_ring (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_valid_i && rx_en), .pop(sel_rxptr && rx_en),
    .din(rx_in), .dout(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_ovr_o <= 1'b0;
    else     rx_ovr_o <= rx_drop;
  end

  // sticky interrupt flags
  logic [NFLAG-1:0] fl_set, fl_clr, fl_q;
  always_comb begin
    fl_set          = '0;
    fl_set[FLAG_RX] = rx_store;
    fl_set[FLAG_TX] = tx_evt;
    fl_clr          = sel_flags ? bus_wdata[NFLAG-1:0] : '0;
  end

  mfifo_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(fl_set), .clr(fl_clr), .flags(fl_q)
  );
  assign irq_rx_o = fl_q[FLAG_RX];
  assign irq_tx_o = fl_q[FLAG_TX];

  // registered read port
  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (bus_addr)
      AW'(A_TXW_ID):  rd_next = tx_win.id;
      AW'(A_TXW_DLC): rd_next = 32'(tx_win.dlc);
      AW'(A_TXW_DLO): rd_next = tx_win.data[31:0];
      AW'(A_TXW_DHI): rd_next = tx_win.data[63:32];
      AW'(A_RXW_ID):  rd_next = rx_head.id;
      AW'(A_RXW_DLC): rd_next = 32'(rx_head.dlc);
      AW'(A_RXW_DLO): rd_next = rx_head.data[31:0];
      AW'(A_RXW_DHI): rd_next = rx_head.data[63:32];
      AW'(A_TXCTL): begin
        rd_next[EN_BIT] = tx_en;
        rd_next[CW:1]   = tx_cnt;
      end
      AW'(A_RXCTL): begin
        rd_next[EN_BIT]    = rx_en;
        rd_next[EMPTY_BIT] = rx_empty;
      end
      AW'(A_FLAGS):   rd_next[NFLAG-1:0] = fl_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (rst)
    rx_ovr_o |-> $past(rx_valid_i && rx_en && rx_full));

  assert_ovr_keeps_full_R8: assert property (@(posedge clk) disable iff (rst)
    rx_ovr_o |-> (rx_full || !rx_en));

  assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_done_i && tx_valid_o) |=> irq_tx_o);

  assert_disable_empties_R10: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> !tx_valid_o);

  assert_full_commit_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_txptr && tx_full && !tx_evt) |=> (tx_cnt == CW'(DEPTH)));
endmodule

// File: tb/can_msg_fifo_tb.sv
module can_msg_fifo_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, bus_wr, tx_done_i, rx_valid_i;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_valid_o, rx_ovr_o, irq_rx_o, irq_tx_o;
  logic [31:0] tx_id_o, rx_id_i;
  logic [3:0]  tx_dlc_o, rx_dlc_i;
  logic [63:0] tx_data_o, rx_data_i;

  can_msg_fifo u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid_o(tx_valid_o), .tx_id_o(tx_id_o), .tx_dlc_o(tx_dlc_o),
    .tx_data_o(tx_data_o), .tx_done_i(tx_done_i),
    .rx_valid_i(rx_valid_i), .rx_id_i(rx_id_i), .rx_dlc_i(rx_dlc_i),
    .rx_data_i(rx_data_i), .rx_ovr_o(rx_ovr_o),
    .irq_rx_o(irq_rx_o), .irq_tx_o(irq_tx_o)
  );

  int total = 0;
  int bad   = 0;
  logic [99:0] txq[$];
  logic [99:0] rxq[$];
  logic        tx_en_m, rx_en_m;
  logic [1:0]  fl_m;
  logic [99:0] win_m;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [99:0] mkf(input logic [31:0] id, input logic [3:0] dlc,
                                      input logic [63:0] d);
    return {id, dlc, d};
  endfunction

  function automatic logic [99:0] rndf();
    return {$urandom, 4'($urandom), $urandom, $urandom};
  endfunction

  // one clock cycle of stimulus, reference update and output check
  task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     input logic td, input logic rv, input logic [99:0] rf,
                     input string tag);
    logic done_eff, commit, popr, acc, ovr, expv;
    done_eff = td && tx_en_m && (txq.size() > 0);
    commit   = wr && (a == 4'd10) && tx_en_m && (txq.size() < 4 || done_eff);
    popr     = wr && (a == 4'd11) && rx_en_m && (rxq.size() > 0);
    acc      = rv && rx_en_m && (rxq.size() < 4 || popr);
    ovr      = rv && rx_en_m && !acc;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    tx_done_i = td; rx_valid_i = rv;
    {rx_id_i, rx_dlc_i, rx_data_i} = rf;
    @(negedge clk);
    bus_wr = 1'b0; tx_done_i = 1'b0; rx_valid_i = 1'b0;
    if (done_eff) void'(txq.pop_front());
    if (commit)   txq.push_back(win_m);
    if (popr)     void'(rxq.pop_front());
    if (acc)      rxq.push_back(rf);
    fl_m = (fl_m & ~((wr && a == 4'd12) ? d[1:0] : 2'b00)) | {done_eff, acc};
    if (wr) begin
      case (a)
        4'd0: win_m[99:68] = d;
        4'd1: win_m[67:64] = d[3:0];
        4'd2: win_m[31:0]  = d;
        4'd3: win_m[63:32] = d;
        4'd8: begin tx_en_m = d[0]; if (!d[0]) txq.delete(); end
        4'd9: begin rx_en_m = d[0]; if (!d[0]) rxq.delete(); end
        default: ;
      endcase
    end
    chk({tag, " overrun"}, rx_ovr_o, ovr);
    expv = tx_en_m && (txq.size() > 0);
    chk({tag, " tx_valid"}, tx_valid_o, expv);
    if (expv) chk({tag, " tx_frame"}, {tx_id_o, tx_dlc_o, tx_data_o}, txq[0]);
    chk({tag, " flags"}, {irq_tx_o, irq_rx_o}, fl_m);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ctl_chk(input string tag);
    rd_chk(4'd8,  {28'h0, 3'(txq.size()), tx_en_m}, {tag, " txctl"});
    rd_chk(4'd9,  {24'h0, (rxq.size() == 0), 6'h0, rx_en_m}, {tag, " rxctl"});
    rd_chk(4'd12, {30'h0, fl_m}, {tag, " flagreg"});
    if (rxq.size() > 0) begin
      rd_chk(4'd4, rxq[0][99:68], {tag, " rx_id"});
      rd_chk(4'd5, {28'h0, rxq[0][67:64]}, {tag, " rx_dlc"});
      rd_chk(4'd6, rxq[0][31:0], {tag, " rx_dlo"});
      rd_chk(4'd7, rxq[0][63:32], {tag, " rx_dhi"});
    end
  endtask

  task automatic wwin(input logic [99:0] f, input string tag);
    cyc(1'b1, 4'd0, f[99:68], 1'b0, 1'b0, '0, tag);
    cyc(1'b1, 4'd1, {28'h0, f[67:64]}, 1'b0, 1'b0, '0, tag);
    cyc(1'b1, 4'd2, f[31:0], 1'b0, 1'b0, '0, tag);
    cyc(1'b1, 4'd3, f[63:32], 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_done_i = 1'b0; rx_valid_i = 1'b0;
    rx_id_i = '0; rx_dlc_i = '0; rx_data_i = '0;
    tx_en_m = 1'b0; rx_en_m = 1'b0; fl_m = 2'b00; win_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_valid", tx_valid_o, 1'b0);
    chk("R1 overrun", rx_ovr_o, 1'b0);
    chk("R1 irq", {irq_tx_o, irq_rx_o}, 2'b00);
    rd_chk(4'd8, 32'h0, "R1 txctl");
    rd_chk(4'd9, 32'h80, "R1 rxctl");
    rd_chk(4'd12, 32'h0, "R1 flagreg");

    // R3 enables, R2 commit and order with extended and remote identifiers
    cyc(1'b1, 4'd8, 32'h1, 1'b0, 1'b0, '0, "R3");
    cyc(1'b1, 4'd9, 32'h1, 1'b0, 1'b0, '0, "R6");
    ctl_chk("R3");
    wwin(mkf(32'h8000_0123, 4'd8, 64'h0807_0605_0403_0201), "R2");
    cyc(1'b1, 4'd10, 32'hFF, 1'b0, 1'b0, '0, "R2");
    wwin(mkf((32'h123 << 18) | 32'h4000_0000, 4'd0, 64'h0), "R2");
    cyc(1'b1, 4'd10, 32'h0, 1'b0, 1'b0, '0, "R2");
    ctl_chk("R3");
    cyc(1'b0, 4'd0, 32'h0, 1'b1, 1'b0, '0, "R5");
    ctl_chk("R5");

    // R4 full transmit queue
    for (int i = 0; i < 3; i++) begin
      wwin(rndf(), "R4");
      cyc(1'b1, 4'd10, 32'hFF, 1'b0, 1'b0, '0, "R4");
    end
    ctl_chk("R4");
    wwin(rndf(), "R4");
    cyc(1'b1, 4'd10, 32'hFF, 1'b0, 1'b0, '0, "R4");
    ctl_chk("R4");
    cyc(1'b1, 4'd10, 32'hFF, 1'b1, 1'b0, '0, "R11");
    ctl_chk("R11");

    // R9 clear and set-wins
    cyc(1'b1, 4'd12, 32'h2, 1'b0, 1'b0, '0, "R9");
    cyc(1'b1, 4'd12, 32'h3, 1'b1, 1'b0, '0, "R9");
    ctl_chk("R9");
    repeat (5) cyc(1'b0, 4'd0, 32'h0, 1'b1, 1'b0, '0, "R5");
    ctl_chk("R5");

    // R6 R8 R7 receive side
    for (int i = 0; i < 4; i++) cyc(1'b0, 4'd0, 32'h0, 1'b0, 1'b1, rndf(), "R6");
    ctl_chk("R6");
    cyc(1'b0, 4'd0, 32'h0, 1'b0, 1'b1, rndf(), "R8");
    ctl_chk("R8");
    cyc(1'b1, 4'd11, 32'h0, 1'b0, 1'b1, rndf(), "R11");
    ctl_chk("R11");
    repeat (4) begin
      cyc(1'b1, 4'd11, 32'h5A, 1'b0, 1'b0, '0, "R7");
      ctl_chk("R7");
    end
    cyc(1'b1, 4'd11, 32'h5A, 1'b0, 1'b0, '0, "R7");
    ctl_chk("R7");
    cyc(1'b1, 4'd12, 32'h3, 1'b0, 1'b0, '0, "R9");
    cyc(1'b0, 4'd0, 32'h0, 1'b0, 1'b1, rndf(), "R9");
    ctl_chk("R9");

    // R10 disables
    wwin(rndf(), "R10");
    cyc(1'b1, 4'd10, 32'hFF, 1'b0, 1'b0, '0, "R10");
    cyc(1'b1, 4'd8, 32'h0, 1'b0, 1'b0, '0, "R10");
    cyc(1'b1, 4'd9, 32'h0, 1'b0, 1'b0, '0, "R10");
    cyc(1'b1, 4'd12, 32'h3, 1'b0, 1'b0, '0, "R10");
    cyc(1'b1, 4'd10, 32'hFF, 1'b1, 1'b0, '0, "R10");
    for (int i = 0; i < 5; i++) cyc(1'b0, 4'd0, 32'h0, 1'b0, 1'b1, rndf(), "R10");
    ctl_chk("R10");
    cyc(1'b1, 4'd8, 32'h1, 1'b0, 1'b0, '0, "R3");
    cyc(1'b1, 4'd9, 32'h1, 1'b0, 1'b0, '0, "R6");

    // random mix, R11 collisions arise often
    for (int it = 0; it < 4000; it++) begin
      int op;
      logic        w;
      logic [3:0]  a;
      logic [31:0] d;
      op = $urandom_range(0, 19);
      w = 1'b1; d = $urandom;
      if (op < 5)       a = 4'($urandom_range(0, 3));
      else if (op < 9)  a = 4'd10;
      else if (op < 13) a = 4'd11;
      else if (op < 14) a = 4'd12;
      else if (op == 14) begin
        a = ($urandom_range(0, 1) == 0) ? 4'd8 : 4'd9;
        d = {31'h0, ($urandom_range(0, 3) != 0)};
      end else begin
        w = 1'b0; a = 4'd0;
      end
      cyc(w, a, d, ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0), rndf(), "R11");
      if (it % 16 == 0) ctl_chk("R11");
    end
    ctl_chk("R11");
    summary();
  end
endmodule